// File: doc/BRIEF.md
# Bus-Loaded FIFO Bridge with Flush Control

This block sits between a simple register bus and a core-side consumer. The bus master pushes 32-bit words by writing a data address. The core pops them in first-in, first-out order with a one-cycle read request. The FIFO is eight entries deep by default, and it runs on a single clock. Each popped word is split into two fields for the core. The low field is `FIELD_A_W` bits wide (20 by default) and the high field holds the remaining bits.

A status/control word at the second bus address reports three items: the number of words held, a full flag and an empty flag. A write of 1 to its flush bit empties the FIFO. That flush bit is a one-shot. It rises on the write and drops when the bus acknowledge is produced. The core side can also flush the FIFO through a dedicated clear input. Each of the two flush sources is a parameter option.

Both flush sources gate the FIFO's own synchronous reset, together with the system reset. A flush therefore returns the storage pointers and the popped-data register to their reset state.

Top module: `bus_fifo_bridge`

## Requirements
- R1: During and after system reset (active-low, synchronous) the outputs take their reset values. `core_empty_o`=1, `core_full_o`=0, `core_count_o`=0, `bus_ack_o`=0, and both field outputs are 0.
- R2: A bus write (`bus_we_i`=1) to address 0 pushes `bus_dat_i` into the FIFO. The new word is counted in `core_count_o` once the access has been acknowledged.
- R3: Words leave in write order. `core_field_a_o` is word bits [FIELD_A_W-1:0] and `core_field_b_o` is word bits [WIDTH-1:FIELD_A_W]. Both update on the clock edge that samples `core_rd_req_i`=1.
- R4: When 8 words are held, `core_full_o`=1. A further write to address 0 is dropped: the count stays 8 and the dropped word never comes out.
- R5: A read request while the FIFO is empty is ignored. The count stays 0 and both field outputs keep their last value.
- R6: A bus read of address 1 returns the status word with these bits: [3:0] = count, 16 = full, 17 = empty. Every other bit, including the flush bit 18, reads 0. A read of address 0 returns 0.
- R7: A bus write of address 1 with bit 18 set flushes the FIFO. The count becomes 0, empty becomes 1, and both field outputs become 0. The same write with bit 18 clear changes nothing.
- R8: The bus flush bit is high for exactly one cycle, the cycle in which the acknowledge is high. After a flush the FIFO accepts and returns words normally.
- R9: `core_clear_i`=1 on a clock edge flushes the FIFO in the same way as R7.
- R10: An access begins on the edge where `bus_cyc_i` and `bus_stb_i` are both high and the slave is idle. `bus_ack_o` is then high for exactly one cycle, two edges after that start. Read data is valid while `bus_ack_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low system reset |
| bus_cyc_i | input | 1 | Bus cycle valid |
| bus_stb_i | input | 1 | Bus strobe, held until acknowledge |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_adr_i | input | 1 | 0 = data push, 1 = status/control |
| bus_dat_i | input | BUS_W | Write data |
| bus_dat_o | output | BUS_W | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| core_rd_req_i | input | 1 | Pop request |
| core_clear_i | input | 1 | Core-side flush |
| core_full_o | output | 1 | FIFO full |
| core_empty_o | output | 1 | FIFO empty |
| core_count_o | output | CNT_W | Words held |
| core_field_a_o | output | FIELD_A_W | Low field of the popped word |
| core_field_b_o | output | WIDTH-FIELD_A_W | High field of the popped word |

## Verification
The bench fills the FIFO to exactly eight words and then writes a ninth. A block with an off-by-one full test would take that word and return it later, or it would wrap its pointers and corrupt the oldest entry. The bench then pops past empty. A design that does not guard an empty pop would move its read pointer or change the field outputs.

The bench checks both polarities of the flush bit. A write with the bit clear must leave the count alone. A write with the bit set must zero the count and the field outputs. Pushes after the flush must be accepted, so a sticky flush bit would show up as a FIFO that never fills again.

The core-side clear is tested separately. The bench also counts the exact edge of the acknowledge, so an acknowledge that arrives one cycle early or late would fail.

// File: rtl/bfb_pkg.sv
package bfb_pkg;

   typedef enum logic {
      BFB_ADR_DATA = 1'b0,
      BFB_ADR_CTRL = 1'b1
   } bfb_adr_e;

   localparam int unsigned BFB_FULL_POS  = 16;
   localparam int unsigned BFB_EMPTY_POS = 17;
   localparam int unsigned BFB_FLUSH_POS = 18;

endpackage

// File: rtl/bfb_bus_slave.sv
module bfb_bus_slave #(
   parameter int unsigned BUS_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             cyc_i,
   input  logic             stb_i,
   input  logic             we_i,
   input  logic             adr_i,
   input  logic [BUS_W-1:0] dat_i,
   output logic             req_o,
   output logic             ack_o,
   output logic             lat_we_o,
   output logic             lat_adr_o,
   output logic [BUS_W-1:0] lat_dat_o
);

   logic start;
   logic req_q;
   logic req_d0;

   assign start = cyc_i & stb_i & ~req_q & ~req_d0;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         req_q     <= 1'b0;
         req_d0    <= 1'b0;
         lat_we_o  <= 1'b0;
         lat_adr_o <= 1'b0;
         lat_dat_o <= '0;
      end else begin
         req_q  <= start;
         req_d0 <= req_q;
         if (start) begin
            lat_we_o  <= we_i;
            lat_adr_o <= adr_i;
            lat_dat_o <= dat_i;
         end
      end
   end

   assign req_o = req_q;
   assign ack_o = req_d0;

   AST_ACK_DELAY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      start |-> ##2 ack_o);                                   // R10
   AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ack_o |=> !ack_o);                                      // R10

endmodule

// File: rtl/bfb_ctrl.sv
module bfb_ctrl #(
   parameter int unsigned BUS_W        = 32,
   parameter int unsigned CNT_W        = 4,
   parameter bit          BUS_CLEAR_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             req_i,
   input  logic             ack_i,
   input  logic             lat_we_i,
   input  logic             lat_adr_i,
   input  logic             lat_flush_bit_i,
   input  logic             full_i,
   input  logic             empty_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [BUS_W-1:0] rd_data_o,
   output logic             flush_o
);
   import bfb_pkg::*;

   logic             ctrl_sel;
   logic [BUS_W-1:0] status;

   assign ctrl_sel = (bfb_adr_e'(lat_adr_i) == BFB_ADR_CTRL);

   always_comb begin
      status                = '0;
      status[CNT_W-1:0]     = count_i;
      status[BFB_FULL_POS]  = full_i;
      status[BFB_EMPTY_POS] = empty_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         rd_data_o <= '0;
      end else if (req_i && !lat_we_i) begin
         rd_data_o <= ctrl_sel ? status : '0;
      end
   end

   generate
      if (BUS_CLEAR_EN) begin : g_bus_flush
         logic flush_q;
         always_ff @(posedge clk_i) begin
            if (!rst_n_i) begin
               flush_q <= 1'b0;
            end else if (req_i && lat_we_i && ctrl_sel && lat_flush_bit_i) begin
               flush_q <= 1'b1;
            end else if (ack_i) begin
               flush_q <= 1'b0;
            end
         end
         assign flush_o = flush_q;

         AST_FLUSH_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            flush_o |=> !flush_o);                            // R8
         AST_FLUSH_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            flush_o |-> ack_i);                               // R8
      end else begin : g_no_bus_flush
         assign flush_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bfb_fifo_core.sv
module bfb_fifo_core #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = PTR_W + 1
) (
   input  logic             clk_i,
   input  logic             srst_n_i,
   input  logic             push_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] dout_o,
   output logic             full_o,
   output logic             empty_o,
   output logic [CNT_W-1:0] count_o
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [CNT_W-1:0] wr_ptr;
   logic [CNT_W-1:0] rd_ptr;
   logic             do_push;
   logic             do_pop;

   assign count_o = wr_ptr - rd_ptr;
   assign full_o  = (count_o == CNT_W'(DEPTH));
   assign empty_o = (count_o == '0);
   assign do_push = push_i & ~full_o;
   assign do_pop  = pop_i & ~empty_o;

   always_ff @(posedge clk_i) begin
      if (do_push) begin
         mem[wr_ptr[PTR_W-1:0]] <= din_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!srst_n_i) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         dout_o <= '0;
      end else begin
         if (do_push) begin
            wr_ptr <= wr_ptr + 1'b1;
         end
         if (do_pop) begin
            rd_ptr <= rd_ptr + 1'b1;
            dout_o <= mem[rd_ptr[PTR_W-1:0]];
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!srst_n_i)
      (full_o && push_i && !pop_i) |=> full_o);               // R4
   AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!srst_n_i)
      (empty_o && pop_i) |=> $stable(dout_o));                // R5
   AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!srst_n_i)
      count_o <= CNT_W'(DEPTH));                              // R4

endmodule

// File: rtl/bus_fifo_bridge.sv
module bus_fifo_bridge #(
   parameter int unsigned BUS_W        = 32,
   parameter int unsigned WIDTH        = 32,
   parameter int unsigned DEPTH        = 8,
   parameter int unsigned FIELD_A_W    = 20,
   parameter bit          DEV_CLEAR_EN = 1'b1,
   parameter bit          BUS_CLEAR_EN = 1'b1,
   localparam int unsigned CNT_W       = $clog2(DEPTH) + 1,
   localparam int unsigned FIELD_B_W   = WIDTH - FIELD_A_W
) (
   input  logic                 clk_i,
   input  logic                 rst_n_i,
   input  logic                 bus_cyc_i,
   input  logic                 bus_stb_i,
   input  logic                 bus_we_i,
   input  logic                 bus_adr_i,
   input  logic [BUS_W-1:0]     bus_dat_i,
   output logic [BUS_W-1:0]     bus_dat_o,
   output logic                 bus_ack_o,
   input  logic                 core_rd_req_i,
   input  logic                 core_clear_i,
   output logic                 core_full_o,
   output logic                 core_empty_o,
   output logic [CNT_W-1:0]     core_count_o,
   output logic [FIELD_A_W-1:0] core_field_a_o,
   output logic [FIELD_B_W-1:0] core_field_b_o
);
   import bfb_pkg::*;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (WIDTH > BUS_W) begin : g_bad_width
         $error("WIDTH must not exceed BUS_W");
      end
      if (FIELD_A_W == 0 || FIELD_A_W >= WIDTH) begin : g_bad_field
         $error("FIELD_A_W must lie between 1 and WIDTH-1");
      end
      if (BUS_W <= BFB_FLUSH_POS || CNT_W > BFB_FULL_POS) begin : g_bad_map
         $error("status word does not fit the bus width");
      end
   endgenerate

   logic             req;
   logic             lat_we;
   logic             lat_adr;
   logic [BUS_W-1:0] lat_dat;
   logic             bus_flush;
   logic             fifo_rst_n;
   logic             push;
   logic [WIDTH-1:0] fifo_dout;

   bfb_bus_slave #(.BUS_W(BUS_W)) u_slave (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .cyc_i     (bus_cyc_i),
      .stb_i     (bus_stb_i),
      .we_i      (bus_we_i),
      .adr_i     (bus_adr_i),
      .dat_i     (bus_dat_i),
      .req_o     (req),
      .ack_o     (bus_ack_o),
      .lat_we_o  (lat_we),
      .lat_adr_o (lat_adr),
      .lat_dat_o (lat_dat)
   );

   bfb_ctrl #(
      .BUS_W        (BUS_W),
      .CNT_W        (CNT_W),
      .BUS_CLEAR_EN (BUS_CLEAR_EN)
   ) u_ctrl (
      .clk_i           (clk_i),
      .rst_n_i         (rst_n_i),
      .req_i           (req),
      .ack_i           (bus_ack_o),
      .lat_we_i        (lat_we),
      .lat_adr_i       (lat_adr),
      .lat_flush_bit_i (lat_dat[BFB_FLUSH_POS]),
      .full_i          (core_full_o),
      .empty_i         (core_empty_o),
      .count_i         (core_count_o),
      .rd_data_o       (bus_dat_o),
      .flush_o         (bus_flush)
   );

   generate
      if (DEV_CLEAR_EN) begin : g_dev_clear
         assign fifo_rst_n = rst_n_i & ~(core_clear_i | bus_flush);
      end else begin : g_no_dev_clear
         assign fifo_rst_n = rst_n_i & ~bus_flush;
      end
   endgenerate

   assign push = req & lat_we & (bfb_adr_e'(lat_adr) == BFB_ADR_DATA);

   bfb_fifo_core #(
      .WIDTH (WIDTH),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk_i    (clk_i),
      .srst_n_i (fifo_rst_n),
      .push_i   (push),
      .din_i    (lat_dat[WIDTH-1:0]),
      .pop_i    (core_rd_req_i),
      .dout_o   (fifo_dout),
      .full_o   (core_full_o),
      .empty_o  (core_empty_o),
      .count_o  (core_count_o)
   );

   assign core_field_a_o = fifo_dout[FIELD_A_W-1:0];
   assign core_field_b_o = fifo_dout[WIDTH-1:FIELD_A_W];

   AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !fifo_rst_n |=> (core_empty_o && core_count_o == '0));  // R7
   AST_FLUSH_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !fifo_rst_n |=> (core_field_a_o == '0 && core_field_b_o == '0)); // R9

endmodule

// File: tb/bus_fifo_bridge_tb.sv
module bus_fifo_bridge_tb;
   localparam int CLK_PERIOD = 10;
   localparam int FA_W = 20;

   localparam logic [31:0] VEC [8] = '{
      32'h1234_5678, 32'hA5A5_0F0F, 32'h0000_0001, 32'hFFFF_FFFF,
      32'h8000_0000, 32'h0BAD_F00D, 32'h7E57_C0DE, 32'h0013_5799
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc = 1'b0, stb = 1'b0, we = 1'b0, adr = 1'b0;
   logic [31:0] dat_w = '0;
   logic [31:0] dat_r;
   logic        ack;
   logic        rd_req = 1'b0, dclr = 1'b0;
   logic        full, empty;
   logic [3:0]  count;
   logic [19:0] fa;
   logic [11:0] fb;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_fifo_bridge u_dut (
      .clk_i(clk), .rst_n_i(rst_n),
      .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we), .bus_adr_i(adr),
      .bus_dat_i(dat_w), .bus_dat_o(dat_r), .bus_ack_o(ack),
      .core_rd_req_i(rd_req), .core_clear_i(dclr),
      .core_full_o(full), .core_empty_o(empty), .core_count_o(count),
      .core_field_a_o(fa), .core_field_b_o(fb)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_xfer(input logic w, input logic a, input logic [31:0] d,
                           output logic [31:0] rd);
      int guard;
      cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat_w = d;
      guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!ack && guard < 20);
      rd = dat_r;
      cyc = 1'b0; stb = 1'b0; we = 1'b0;
      @(negedge clk);
   endtask

   task automatic pop_one();
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   function automatic logic [31:0] status(input int c, input bit f, input bit e);
      return 32'(c) | (32'(f) << 16) | (32'(e) << 17);
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R1 reset state while reset held
      chk("R1 empty in reset", 32'(empty), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 empty", 32'(empty), 32'd1);
      chk("R1 full", 32'(full), 32'd0);
      chk("R1 count", 32'(count), 32'd0);
      chk("R1 ack", 32'(ack), 32'd0);
      chk("R1 fields", {fb, fa}, 32'd0);

      // R10 acknowledge timing, first push
      cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = 1'b0; dat_w = VEC[0];
      @(negedge clk);
      chk("R10 no ack one edge after start", 32'(ack), 32'd0);
      @(negedge clk);
      chk("R10 ack two edges after start", 32'(ack), 32'd1);
      cyc = 1'b0; stb = 1'b0; we = 1'b0;
      @(negedge clk);
      chk("R10 ack single cycle", 32'(ack), 32'd0);
      chk("R2 count after first push", 32'(count), 32'd1);

      // vector table walk: R2 pushes
      for (int i = 1; i < 8; i++) begin
         bus_xfer(1'b1, 1'b0, VEC[i], rd);
         chk("R2 count after push", 32'(count), 32'(i + 1));
      end
      chk("R4 full at 8", 32'(full), 32'd1);
      bus_xfer(1'b0, 1'b1, 32'd0, rd);
      chk("R6 status when full", rd, status(8, 1'b1, 1'b0));
      bus_xfer(1'b1, 1'b0, 32'hDEAD_BEEF, rd);
      chk("R4 count after dropped write", 32'(count), 32'd8);

      // R3 order and field split
      for (int i = 0; i < 8; i++) begin
         pop_one();
         chk("R3 field a", 32'(fa), 32'(VEC[i][FA_W-1:0]));
         chk("R3 field b", 32'(fb), 32'(VEC[i][31:FA_W]));
      end
      chk("R4 empty after draining 8", 32'(empty), 32'd1);

      // R5 pop on empty is ignored
      pop_one();
      chk("R5 field a holds", 32'(fa), 32'(VEC[7][FA_W-1:0]));
      chk("R5 field b holds", 32'(fb), 32'(VEC[7][31:FA_W]));
      chk("R5 count stays 0", 32'(count), 32'd0);
      bus_xfer(1'b0, 1'b1, 32'd0, rd);
      chk("R6 status when empty", rd, status(0, 1'b0, 1'b1));
      bus_xfer(1'b0, 1'b0, 32'd0, rd);
      chk("R6 data address reads 0", rd, 32'd0);

      // R7 flush bit polarity
      for (int i = 0; i < 3; i++) bus_xfer(1'b1, 1'b0, VEC[i], rd);
      bus_xfer(1'b1, 1'b1, 32'hFFFB_FFFF, rd);
      chk("R7 write with bit 18 clear keeps count", 32'(count), 32'd3);
      bus_xfer(1'b0, 1'b1, 32'd0, rd);
      chk("R6 status with 3 words, bit 18 reads 0", rd, status(3, 1'b0, 1'b0));
      bus_xfer(1'b1, 1'b1, 32'h0004_0000, rd);
      chk("R7 flush count", 32'(count), 32'd0);
      chk("R7 flush empty", 32'(empty), 32'd1);
      chk("R7 flush fields", {fb, fa}, 32'd0);

      // R8 flush is not sticky
      bus_xfer(1'b1, 1'b0, VEC[5], rd);
      chk("R8 push after flush", 32'(count), 32'd1);
      pop_one();
      chk("R8 word after flush", {fb, fa}, VEC[5]);

      // R9 core-side clear
      bus_xfer(1'b1, 1'b0, VEC[6], rd);
      bus_xfer(1'b1, 1'b0, VEC[7], rd);
      chk("R9 count before clear", 32'(count), 32'd2);
      dclr = 1'b1;
      @(negedge clk);
      dclr = 1'b0;
      chk("R9 count after clear", 32'(count), 32'd0);
      chk("R9 empty after clear", 32'(empty), 32'd1);
      chk("R9 fields after clear", {fb, fa}, 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule